// File: doc/BRIEF.md
# DAC Output Update Arbiter

This block decides when the code driving a precision DAC changes. It holds two words: the staged DAC word and a programmable clear word. From them it forms the code presented to the converter. Three active-low hardware pins control it: load, clear and reset. Each pin is synchronized and watched for both level and edge. Three single-cycle software strobes arrive from the serial register decoder and act alongside the pins.

The pins and the strobes can disagree, so the block applies a fixed priority. Reset comes first. A low clear pin comes next. It forces the clear word into both the staged register and the output. A low load pin makes the output track the staged register. A software strobe takes effect only when the opposite pin does not mask it. The held code is stored in the coding selected by the host. It is converted to a straight unsigned code for the converter. Every change of that code raises a one-cycle update pulse.

Top module: `dac_update_ctrl`

## Requirements
- R1: While the reset pin is low, both registers stay at their power-on values (staged 0, clear word 0). Write strobes have no effect.
- R2: The power-on state is staged word 0, clear word 0 and held code 0. It is restored by a reset pin release and by the software reset strobe. With the twos-complement coding (`fmt_offset_bin`=0) this gives output 0x80000 (20-bit default).
- R3: With reset high and the clear pin low, the staged register and the output both take the clear word, whatever the load pin level.
- R4: With reset and clear high and the load pin low, the output follows the staged register, including later writes to it.
- R5: When the clear pin rises with load high, the output keeps the clear word. When it rises with load low, the output returns to tracking the staged register.
- R6: With both pins high, the software load strobe copies the staged register to the output. While the clear pin is low, neither the load strobe nor a staged write moves the output or staged register off the clear word.
- R7: With both pins high, the software clear strobe loads the clear word into the staged register and the output. While the load pin is low it is ignored: the staged register and output keep their value.
- R8: With `fmt_offset_bin`=1 the output code equals the held code. With 0 (twos complement) the output is the held code with its MSB inverted.
- R9: `out_upd` is high for exactly the cycles in which `out_code` has just changed, and low otherwise.
- R10: With both pins high and no strobe, writes to the staged register do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ldac_pin_n | input | 1 | Asynchronous active-low load pin |
| clr_pin_n | input | 1 | Asynchronous active-low clear pin |
| rst_pin_n | input | 1 | Asynchronous active-low device reset pin |
| sw_load | input | 1 | Software load strobe, one cycle |
| sw_clear | input | 1 | Software clear strobe, one cycle |
| sw_reset | input | 1 | Software reset strobe, one cycle |
| dac_wr | input | 1 | Write `wr_data` to the staged register |
| clr_wr | input | 1 | Write `wr_data` to the clear word |
| wr_data | input | CODE_W | Write data from the register decoder |
| fmt_offset_bin | input | 1 | 1 = offset binary, 0 = twos complement |
| dac_reg_q | output | CODE_W | Staged register contents |
| clear_code_q | output | CODE_W | Clear word contents |
| out_code | output | CODE_W | Unsigned code to the converter |
| out_upd | output | 1 | One-cycle pulse on every output change |

## Verification
Directed scenarios walk the pin combinations one at a time: load low alone, clear low with load either way, and the clear release with load high and with load low. Distinct data words are written in between, so tracking, holding and clearing give different outputs. The strobes are tried twice, once with the masking pin inactive and once with it active. The masked cases are told apart by writing a different clear word or staged word first. The coding cases use words whose MSB is both set and clear. The pulse count is compared for a real change, a repeat load of the same value and a coding flip.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_INIT  = 2'd1,
      ACT_CLEAR = 2'd2,
      ACT_LOAD  = 2'd3
   } dacu_act_e;

   localparam int unsigned PIN_LDAC  = 0;
   localparam int unsigned PIN_CLR   = 1;
   localparam int unsigned PIN_RST   = 2;
   localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/dacu_pin_sync.sv
module dacu_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic lvl,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dacu_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_n};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise, fall})); // R5
endmodule

// File: rtl/dacu_arbiter.sv
module dacu_arbiter
   import dacu_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rst_lvl,
   input  logic      rst_rise,
   input  logic      rst_fall,
   input  logic      clr_lvl,
   input  logic      clr_rise,
   input  logic      clr_fall,
   input  logic      ld_lvl,
   input  logic      ld_rise,
   input  logic      ld_fall,
   input  logic      sw_load,
   input  logic      sw_clear,
   input  logic      sw_reset,
   output dacu_act_e act
);
   logic pins_free;

   always_comb begin
      if (!rst_lvl || rst_rise || sw_reset) act = ACT_INIT;
      else if (!clr_lvl)                    act = ACT_CLEAR;
      else if (!ld_lvl)                     act = ACT_LOAD;
      else if (sw_clear)                    act = ACT_CLEAR;
      else if (sw_load)                     act = ACT_LOAD;
      else                                  act = ACT_NONE;
   end

   assign pins_free = rst_lvl && !rst_rise && !sw_reset;

   AST_RESET_FALL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      rst_fall |-> act == ACT_INIT); // R1
   AST_CLR_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_free && clr_fall) |-> act == ACT_CLEAR); // R3
   AST_LD_FALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_free && clr_lvl && ld_fall) |-> act == ACT_LOAD); // R4
   AST_CLR_RISE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_free && clr_rise && ld_lvl && !sw_load && !sw_clear) |-> act == ACT_NONE); // R5
   AST_LD_RISE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_free && ld_rise && clr_lvl && !sw_load && !sw_clear) |-> act == ACT_NONE); // R10
endmodule

// File: rtl/dacu_code_regs.sv
module dacu_code_regs
   import dacu_pkg::*;
#(
   parameter int unsigned         CODE_W   = 20,
   parameter logic [CODE_W-1:0]   DAC_INIT = '0,
   parameter logic [CODE_W-1:0]   CLR_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dacu_act_e         act,
   input  logic              dac_wr,
   input  logic              clr_wr,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              fmt_offset_bin,
   output logic [CODE_W-1:0] dac_q,
   output logic [CODE_W-1:0] clr_q,
   output logic [CODE_W-1:0] code_q,
   output logic              upd_q
);
   localparam int unsigned MSB = CODE_W - 1;

   generate
      if (CODE_W < 2 || CODE_W > 32) begin : g_bad_width
         $error("dacu_code_regs: CODE_W must lie in 2..32");
      end
   endgenerate

   function automatic logic [CODE_W-1:0] to_unsigned(input logic [CODE_W-1:0] c,
                                                    input logic offset_bin);
      to_unsigned = offset_bin ? c : {~c[MSB], c[MSB-1:0]};
   endfunction

   logic [CODE_W-1:0] held_q, held_d, dac_d, clr_d, code_d;

   always_comb begin
      held_d = held_q;
      dac_d  = dac_wr ? wr_data : dac_q;
      clr_d  = clr_wr ? wr_data : clr_q;
      unique case (act)
         ACT_INIT: begin
            held_d = DAC_INIT;
            dac_d  = DAC_INIT;
            clr_d  = CLR_INIT;
         end
         ACT_CLEAR: begin
            held_d = clr_q;
            dac_d  = clr_q;
         end
         ACT_LOAD:  held_d = dac_q;
         default:   held_d = held_q;
      endcase
      code_d = to_unsigned(held_d, fmt_offset_bin);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q  <= DAC_INIT;
         clr_q  <= CLR_INIT;
         held_q <= DAC_INIT;
         code_q <= to_unsigned(DAC_INIT, 1'b0);
         upd_q  <= 1'b0;
      end else begin
         dac_q  <= dac_d;
         clr_q  <= clr_d;
         held_q <= held_d;
         code_q <= code_d;
         upd_q  <= (code_d != code_q);
      end
   end

   AST_INIT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      act == ACT_INIT |=> (dac_q == DAC_INIT && clr_q == CLR_INIT && held_q == DAC_INIT)); // R2
   AST_CLEAR_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      act == ACT_CLEAR |=> (dac_q == $past(clr_q) && held_q == $past(clr_q))); // R3
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      act == ACT_LOAD |=> held_q == $past(dac_q)); // R4
   AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      act == ACT_NONE |=> held_q == $past(held_q)); // R10
   AST_UPD_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> code_q != $past(code_q)); // R9
   AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |-> $stable(code_q)); // R9
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
   import dacu_pkg::*;
#(
   parameter int unsigned       CODE_W      = 20,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [CODE_W-1:0] DAC_INIT    = '0,
   parameter logic [CODE_W-1:0] CLR_INIT    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ldac_pin_n,
   input  logic              clr_pin_n,
   input  logic              rst_pin_n,
   input  logic              sw_load,
   input  logic              sw_clear,
   input  logic              sw_reset,
   input  logic              dac_wr,
   input  logic              clr_wr,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              fmt_offset_bin,
   output logic [CODE_W-1:0] dac_reg_q,
   output logic [CODE_W-1:0] clear_code_q,
   output logic [CODE_W-1:0] out_code,
   output logic              out_upd
);
   logic [PIN_COUNT-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
   dacu_act_e            act;

   assign pin_raw[PIN_LDAC] = ldac_pin_n;
   assign pin_raw[PIN_CLR]  = clr_pin_n;
   assign pin_raw[PIN_RST]  = rst_pin_n;

   generate
      for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
         dacu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (pin_raw[p]),
            .lvl   (pin_lvl[p]),
            .rise  (pin_rise[p]),
            .fall  (pin_fall[p])
         );
      end
   endgenerate

   dacu_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_lvl  (pin_lvl[PIN_RST]),
      .rst_rise (pin_rise[PIN_RST]),
      .rst_fall (pin_fall[PIN_RST]),
      .clr_lvl  (pin_lvl[PIN_CLR]),
      .clr_rise (pin_rise[PIN_CLR]),
      .clr_fall (pin_fall[PIN_CLR]),
      .ld_lvl   (pin_lvl[PIN_LDAC]),
      .ld_rise  (pin_rise[PIN_LDAC]),
      .ld_fall  (pin_fall[PIN_LDAC]),
      .sw_load  (sw_load),
      .sw_clear (sw_clear),
      .sw_reset (sw_reset),
      .act      (act)
   );

   dacu_code_regs #(
      .CODE_W   (CODE_W),
      .DAC_INIT (DAC_INIT),
      .CLR_INIT (CLR_INIT)
   ) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .act            (act),
      .dac_wr         (dac_wr),
      .clr_wr         (clr_wr),
      .wr_data        (wr_data),
      .fmt_offset_bin (fmt_offset_bin),
      .dac_q          (dac_reg_q),
      .clr_q          (clear_code_q),
      .code_q         (out_code),
      .upd_q          (out_upd)
   );
endmodule

// File: tb/dac_update_ctrl_bench.sv
module dac_update_ctrl_bench;
   localparam int W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ldac_pin_n = 1'b1, clr_pin_n = 1'b1, rst_pin_n = 1'b1;
   logic sw_load = 1'b0, sw_clear = 1'b0, sw_reset = 1'b0;
   logic dac_wr = 1'b0, clr_wr = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic fmt_offset_bin = 1'b0;
   logic [W-1:0] dac_reg_q, clear_code_q, out_code;
   logic out_upd;

   int checks = 0, errors = 0, pulses = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dac_update_ctrl #(.CODE_W(W)) u_dac_update_ctrl (
      .clk(clk), .rst_n(rst_n), .ldac_pin_n(ldac_pin_n), .clr_pin_n(clr_pin_n),
      .rst_pin_n(rst_pin_n), .sw_load(sw_load), .sw_clear(sw_clear),
      .sw_reset(sw_reset), .dac_wr(dac_wr), .clr_wr(clr_wr), .wr_data(wr_data),
      .fmt_offset_bin(fmt_offset_bin), .dac_reg_q(dac_reg_q),
      .clear_code_q(clear_code_q), .out_code(out_code), .out_upd(out_upd)
   );

   always @(posedge clk) if (rst_n && out_upd) pulses++;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr_dac(input logic [W-1:0] v);
      wr_data = v; dac_wr = 1'b1; step(1); dac_wr = 1'b0; step(3);
   endtask

   task automatic wr_clr(input logic [W-1:0] v);
      wr_data = v; clr_wr = 1'b1; step(1); clr_wr = 1'b0; step(3);
   endtask

   task automatic pulse_load();  sw_load  = 1'b1; step(1); sw_load  = 1'b0; step(3); endtask
   task automatic pulse_clear(); sw_clear = 1'b1; step(1); sw_clear = 1'b0; step(3); endtask

   task automatic t_power_on();
      check("R2", "power-on staged", dac_reg_q, '0);
      check("R2", "power-on clear word", clear_code_q, '0);
      check("R2", "power-on output midscale", out_code, 20'h80000);
      check("R9", "no pulse at power-on", {19'd0, out_upd}, '0);
   endtask

   task automatic t_load_low();
      fmt_offset_bin = 1'b1; step(2);
      ldac_pin_n = 1'b0; step(5);
      wr_dac(20'h12345);
      check("R4", "output follows staged write", out_code, 20'h12345);
      wr_dac(20'h54321);
      check("R4", "output follows second write", out_code, 20'h54321);
   endtask

   task automatic t_hold_and_swload();
      ldac_pin_n = 1'b1; step(5);
      wr_dac(20'h0AAAA);
      check("R10", "output holds with pins high", out_code, 20'h54321);
      check("R10", "staged register took write", dac_reg_q, 20'h0AAAA);
      pulse_load();
      check("R6", "software load updates output", out_code, 20'h0AAAA);
   endtask

   task automatic t_clear_level();
      wr_clr(20'hFFFFF);
      clr_pin_n = 1'b0; step(5);
      check("R3", "clear pin loads output", out_code, 20'hFFFFF);
      check("R3", "clear pin loads staged", dac_reg_q, 20'hFFFFF);
      ldac_pin_n = 1'b0; step(5);
      check("R3", "clear wins over load low", out_code, 20'hFFFFF);
      ldac_pin_n = 1'b1; step(5);
      wr_data = 20'h11111; dac_wr = 1'b1; sw_load = 1'b1; step(1);
      dac_wr = 1'b0; sw_load = 1'b0; step(3);
      check("R6", "software load masked by clear pin", out_code, 20'hFFFFF);
      check("R6", "staged stays at clear word", dac_reg_q, 20'hFFFFF);
   endtask

   task automatic t_clear_release();
      clr_pin_n = 1'b1; step(5);
      check("R5", "clear release with load high keeps clear word", out_code, 20'hFFFFF);
      wr_dac(20'h22222);
      check("R10", "write after release does not move output", out_code, 20'hFFFFF);
      wr_clr(20'h33333);
      ldac_pin_n = 1'b0; clr_pin_n = 1'b0; step(5);
      check("R3", "clear with load low", out_code, 20'h33333);
      clr_pin_n = 1'b1; step(5);
      wr_dac(20'h44444);
      check("R5", "clear release with load low tracks staged", out_code, 20'h44444);
   endtask

   task automatic t_swclear();
      ldac_pin_n = 1'b1; step(5);
      wr_clr(20'h55555);
      pulse_clear();
      check("R7", "software clear loads output", out_code, 20'h55555);
      check("R7", "software clear loads staged", dac_reg_q, 20'h55555);
      ldac_pin_n = 1'b0; step(5);
      wr_dac(20'h66666);
      wr_clr(20'h77777);
      pulse_clear();
      check("R7", "software clear masked: output", out_code, 20'h66666);
      check("R7", "software clear masked: staged", dac_reg_q, 20'h66666);
   endtask

   task automatic t_coding();
      fmt_offset_bin = 1'b0; step(3);
      check("R8", "twos complement inverts MSB", out_code, 20'hE6666);
      wr_dac(20'h80001);
      check("R8", "twos complement negative word", out_code, 20'h00001);
      fmt_offset_bin = 1'b1; step(3);
      check("R8", "offset binary passes code", out_code, 20'h80001);
   endtask

   task automatic t_pulses();
      ldac_pin_n = 1'b1; step(5);
      wr_dac(20'h12000);
      pulses = 0;
      pulse_load();
      check("R9", "one pulse on change", pulses, 1);
      pulses = 0;
      pulse_load();
      check("R9", "no pulse on same value", pulses, 0);
      pulses = 0;
      fmt_offset_bin = 1'b0; step(4);
      check("R9", "one pulse on coding flip", pulses, 1);
   endtask

   task automatic t_resets();
      wr_clr(20'h0F0F0);
      rst_pin_n = 1'b0; step(5);
      check("R1", "reset pin clears staged", dac_reg_q, '0);
      check("R1", "reset pin clears clear word", clear_code_q, '0);
      wr_dac(20'h0ABCD);
      wr_clr(20'h0DCBA);
      check("R1", "staged write ignored in reset", dac_reg_q, '0);
      check("R1", "clear write ignored in reset", clear_code_q, '0);
      rst_pin_n = 1'b1; step(5);
      check("R2", "released output at power-on", out_code, 20'h80000);
      wr_dac(20'h31313);
      wr_clr(20'h13131);
      pulse_load();
      check("R6", "load works after release", out_code, 20'hB1313);
      sw_reset = 1'b1; step(1); sw_reset = 1'b0; step(3);
      check("R2", "software reset staged", dac_reg_q, '0);
      check("R2", "software reset clear word", clear_code_q, '0);
      check("R2", "software reset output", out_code, 20'h80000);
   endtask

   initial begin
      step(4);
      rst_n = 1'b1;
      step(4);
      t_power_on();
      t_load_low();
      t_hold_and_swload();
      t_clear_level();
      t_clear_release();
      t_swclear();
      t_coding();
      t_pulses();
      t_resets();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule